// File: doc/BRIEF.md
# Display Channel Ditherer

This block reduces 10-bit-per-channel RGB pixels to a smaller physical depth for a display panel. Each of the three channels is set on its own to 5, 6, 7 or 8 output bits. The block keeps the appearance of the full 10-bit code by choosing between the two nearest physical levels. It chooses the higher level for a share of pixels that matches the value of the bits it drops.

The choice is made against a threshold from a 4x4 ordered matrix. In spatial mode the threshold depends only on the pixel's position within a 4x4 tile. In temporal mode an internal frame counter, advanced by a frame-start pulse, moves through the matrix. Each pixel then sees every threshold once over 16 frames. The counter also combines with the position, so neighbouring pixels do not change in step. A per-pixel enable bit, carried with the pixel (the alpha bit), switches dithering off for that pixel. The pixel is then plainly truncated. The result is registered once and leaves with its valid flag.

Top module: `pixel_dither`

## Requirements
- R1: While reset is high, and on the first clock after it, `out_valid` is 0 and `out_rgb` is all zeros. The frame counter restarts at 0.
- R2: `out_valid` equals `in_valid` from one clock earlier. When `in_valid` is high, `out_rgb` shows that pixel's result one clock later. When `in_valid` is low, `out_rgb` keeps its previous value.
- R3: Each 2-bit depth selector maps 0, 1, 2 and 3 to 5, 6, 7 and 8 physical bits. The result is right-aligned in its 8-bit output field, and the bits above the selected depth are zero.
- R4: When `in_dither_en` is 0, each channel output equals the input code shifted right by (10 - depth).
- R5: In spatial mode (`cfg_temporal` = 0), with k = 10 - depth dropped bits, the output is the truncated code plus 1 exactly when (dropped bits << (5 - k)) > 2*B. B = {a[0], y[0], a[1], y[1]}, where a = x XOR y on the 2-bit position inputs.
- R6: In temporal mode (`cfg_temporal` = 1), the rule of R5 applies with B taken at column x XOR f[1:0] and row y XOR f[3:2], where f is the 4-bit frame counter.
- R7: Each `frame_start` pulse adds 1 to the frame counter, which wraps from 15 to 0. A pixel presented in the same cycle as the pulse uses the count from before the pulse.
- R8: A truncated code that is already all ones at the selected depth is never rounded up, so the output saturates at 2^depth - 1.
- R9: Channel fields are R = `in_rgb[29:20]`, G = `[19:10]`, B = `[9:0]`. They map to `out_rgb` fields [23:16], [15:8], [7:0], with depth selectors `cfg_depth[5:4]`, `[3:2]`, `[1:0]`. Each channel uses only its own selector and data.
- R10: A pixel whose dropped bits are all zero leaves unchanged (its truncated code) at every position and frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel present this cycle |
| in_rgb | input | 30 | Three 10-bit channel codes, R in the top field |
| in_dither_en | input | 1 | Per-pixel dither enable (alpha bit) |
| pos_x | input | 2 | Low two bits of the pixel column |
| pos_y | input | 2 | Low two bits of the pixel row |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| cfg_depth | input | 6 | Three 2-bit physical depth selectors |
| cfg_temporal | input | 1 | 0 = spatial pattern, 1 = temporal sequence |
| out_valid | output | 1 | Result valid |
| out_rgb | output | 24 | Three right-aligned 8-bit physical codes |

## Verification
The temporal thresholds are the hardest to reach from the ports. They depend on a hidden frame count that moves only through `frame_start` pulses. The stimulus therefore walks through more than sixteen frames, so the count wraps. In each frame it sweeps all sixteen tile positions, which exposes every combination of count and position. It also raises a pulse in the same cycle as a valid pixel, to pin down which count that pixel sees.

// File: rtl/dither_pkg.sv
package dither_pkg;

    localparam int DEF_IN_W   = 10;
    localparam int DEF_OUT_W  = 8;
    localparam int DEPTH_OPTS = 4;
    localparam int SEL_W      = $clog2(DEPTH_OPTS);
    localparam int TH_W       = 4;
    localparam int FCNT_W     = 4;

    typedef enum logic {
        MODE_SPATIAL  = 1'b0,
        MODE_TEMPORAL = 1'b1
    } dmode_e;

    // Ordered 4x4 threshold: bit-reversed interleave of (col ^ row) and row.
    function automatic logic [TH_W-1:0] bayer4(input logic [1:0] cx, input logic [1:0] cy);
        logic [1:0] a;
        a = cx ^ cy;
        return {a[0], cy[0], a[1], cy[1]};
    endfunction

endpackage

// File: rtl/dither_thresh.sv
module dither_thresh
    import dither_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_start,
    input  dmode_e          mode,
    input  logic [1:0]      pos_x,
    input  logic [1:0]      pos_y,
    output logic [TH_W-1:0] thr
);

    logic [FCNT_W-1:0] fcnt;

    always_ff @(posedge clk) begin
        if (rst)              fcnt <= '0;
        else if (frame_start) fcnt <= fcnt + 1'b1;
    end

    always_comb begin
        if (mode == MODE_TEMPORAL)
            thr = bayer4(pos_x ^ fcnt[1:0], pos_y ^ fcnt[3:2]);
        else
            thr = bayer4(pos_x, pos_y);
    end

endmodule

// File: rtl/dither_chan.sv
module dither_chan
    import dither_pkg::*;
#(
    parameter int IN_W  = DEF_IN_W,
    parameter int OUT_W = DEF_OUT_W
) (
    input  logic [IN_W-1:0]  in_val,
    input  logic [SEL_W-1:0] depth_sel,
    input  logic             en,
    input  logic [TH_W-1:0]  thr,
    output logic [OUT_W-1:0] out_code
);

    localparam int MIN_D = OUT_W - (DEPTH_OPTS - 1);
    localparam int FR_W  = IN_W - MIN_D;
    localparam int SH_W  = $clog2(IN_W + 1);

    logic [SH_W-1:0] k;
    logic [IN_W-1:0] trunc, maxc, frac, fnorm, tnorm;
    logic            up;

    always_comb begin
        k     = SH_W'(FR_W) - SH_W'(depth_sel);
        trunc = in_val >> k;
        maxc  = {IN_W{1'b1}} >> k;
        frac  = in_val & ~({IN_W{1'b1}} << k);
        fnorm = frac << (SH_W'(FR_W) - k);
        tnorm = IN_W'(thr) << (FR_W - TH_W);
        up    = en && (trunc != maxc) && (fnorm > tnorm);
        out_code = trunc[OUT_W-1:0] + OUT_W'(up);
    end

endmodule

// File: rtl/pixel_dither.sv
module pixel_dither
    import dither_pkg::*;
#(
    parameter int IN_W  = DEF_IN_W,
    parameter int OUT_W = DEF_OUT_W,
    parameter int NCH   = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [NCH*IN_W-1:0]  in_rgb,
    input  logic                 in_dither_en,
    input  logic [1:0]           pos_x,
    input  logic [1:0]           pos_y,
    input  logic                 frame_start,
    input  logic [NCH*SEL_W-1:0] cfg_depth,
    input  logic                 cfg_temporal,
    output logic                 out_valid,
    output logic [NCH*OUT_W-1:0] out_rgb
);

    logic [TH_W-1:0]      thr;
    logic [NCH*OUT_W-1:0] q;
    dmode_e               mode;

    assign mode = cfg_temporal ? MODE_TEMPORAL : MODE_SPATIAL;

    dither_thresh u_thresh (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .mode        (mode),
        .pos_x       (pos_x),
        .pos_y       (pos_y),
        .thr         (thr)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        dither_chan #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chan (
            .in_val    (in_rgb[ch*IN_W +: IN_W]),
            .depth_sel (cfg_depth[ch*SEL_W +: SEL_W]),
            .en        (in_dither_en),
            .thr       (thr),
            .out_code  (q[ch*OUT_W +: OUT_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_rgb <= q;
        end
    end

endmodule

// File: rtl/pixel_dither_chk.sv
module pixel_dither_chk
    import dither_pkg::*;
#(
    parameter int IN_W  = DEF_IN_W,
    parameter int OUT_W = DEF_OUT_W,
    parameter int NCH   = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [NCH*IN_W-1:0]  in_rgb,
    input logic                 in_dither_en,
    input logic [NCH*SEL_W-1:0] cfg_depth,
    input logic                 out_valid,
    input logic [NCH*OUT_W-1:0] out_rgb
);

    localparam int MIN_D = OUT_W - (DEPTH_OPTS - 1);
    localparam int FR_W  = IN_W - MIN_D;
    localparam int SH_W  = $clog2(IN_W + 1);

    logic                 armed, pv, pen;
    logic [NCH*IN_W-1:0]  pin;
    logic [NCH*SEL_W-1:0] pdep;

    always_ff @(posedge clk) begin
        armed <= !rst;
        pv    <= in_valid;
        pen   <= in_dither_en;
        pin   <= in_rgb;
        pdep  <= cfg_depth;
    end

    // R1: cleared output on the clock after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (out_valid == 1'b0 && out_rgb == '0));

    // R2: valid follows one clock later
    a_r2_valid_follow: assert property (@(posedge clk) disable iff (rst)
        armed |-> (out_valid == pv));

    // R2: data held while no pixel arrives
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (armed && !pv) |-> $stable(out_rgb));

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        logic [SH_W-1:0] k;
        logic [IN_W-1:0] tr, mx, oc;
        logic            fz;
        always_comb begin
            k  = SH_W'(FR_W) - SH_W'(pdep[ch*SEL_W +: SEL_W]);
            tr = pin[ch*IN_W +: IN_W] >> k;
            mx = {IN_W{1'b1}} >> k;
            fz = (pin[ch*IN_W +: IN_W] & ~({IN_W{1'b1}} << k)) == '0;
            oc = IN_W'(out_rgb[ch*OUT_W +: OUT_W]);
        end

        // R4: disabled pixel is plain truncation
        a_r4_plain: assert property (@(posedge clk) disable iff (rst)
            (armed && pv && !pen) |-> (oc == tr));

        // R5: result is the lower or the next physical level
        a_r5_step: assert property (@(posedge clk) disable iff (rst)
            (armed && pv) |-> (oc == tr || oc == tr + 1'b1));

        // R3 / R8: never beyond the top code of the selected depth
        a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
            (armed && pv) |-> (oc <= mx));

        // R10: exact codes pass unchanged
        a_r10_exact: assert property (@(posedge clk) disable iff (rst)
            (armed && pv && fz) |-> (oc == tr));
    end

endmodule

bind pixel_dither pixel_dither_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .NCH(NCH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_rgb       (in_rgb),
    .in_dither_en (in_dither_en),
    .cfg_depth    (cfg_depth),
    .out_valid    (out_valid),
    .out_rgb      (out_rgb)
);

// File: tb/pixel_dither_bench.sv
`timescale 1ns/1ps
module pixel_dither_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [29:0] in_rgb = '0;
    logic        in_dither_en = 1'b0;
    logic [1:0]  pos_x = '0;
    logic [1:0]  pos_y = '0;
    logic        frame_start = 1'b0;
    logic [5:0]  cfg_depth = '0;
    logic        cfg_temporal = 1'b0;
    logic        out_valid;
    logic [23:0] out_rgb;

    int checks = 0;
    int fails  = 0;
    int fcnt   = 0;
    int dr = 0, dg = 0, db = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pixel_dither u_pixel_dither (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_rgb(in_rgb),
        .in_dither_en(in_dither_en), .pos_x(pos_x), .pos_y(pos_y),
        .frame_start(frame_start), .cfg_depth(cfg_depth),
        .cfg_temporal(cfg_temporal), .out_valid(out_valid), .out_rgb(out_rgb)
    );

    function automatic int bay(input int x, input int y);
        int a;
        a = (x ^ y) & 3;
        return ((a & 1) << 3) | ((y & 1) << 2) | (((a >> 1) & 1) << 1) | ((y >> 1) & 1);
    endfunction

    function automatic logic [7:0] model(input int v, input int dc, input bit en, input int b);
        int d, k, code, frac, maxc;
        d = 5 + dc; k = 10 - d;
        code = v >> k; frac = v & ((1 << k) - 1); maxc = (1 << d) - 1;
        if (!en || code == maxc) return 8'(code);
        if ((frac << (5 - k)) > 2 * b) return 8'(code + 1);
        return 8'(code);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [24:0] act, input logic [24:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_depth(input int r, input int g, input int b);
        dr = r; dg = g; db = b;
        cfg_depth = {2'(r), 2'(g), 2'(b)};
    endtask

    task automatic px(input int r, input int g, input int b, input bit en,
                      input int x, input int y, input bit fs, input string tag);
        int bt;
        logic [23:0] exp;
        if (cfg_temporal) bt = bay((x ^ fcnt) & 3, (y ^ (fcnt >> 2)) & 3);
        else              bt = bay(x & 3, y & 3);
        exp = {model(r, dr, en, bt), model(g, dg, en, bt), model(b, db, en, bt)};
        in_rgb = {10'(r), 10'(g), 10'(b)};
        in_dither_en = en; pos_x = 2'(x); pos_y = 2'(y);
        frame_start = fs; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; frame_start = 1'b0;
        if (fs) fcnt = (fcnt + 1) % 16;
        check(out_valid === 1'b1 && out_rgb === exp, tag, {out_valid, out_rgb}, {1'b1, exp});
    endtask

    task automatic pulse();
        frame_start = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        frame_start = 1'b0;
        fcnt = (fcnt + 1) % 16;
        check(out_valid === 1'b0, "R2 idle after pulse", {24'd0, out_valid}, 25'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [23:0] held;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && out_rgb === '0, "R1 in reset", {out_valid, out_rgb}, 25'd0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0 && out_rgb === '0, "R1 after reset", {out_valid, out_rgb}, 25'd0);

        // R5 / R3: spatial sweep, every depth, every tile position
        cfg_temporal = 1'b0;
        for (int dc = 0; dc < 4; dc++) begin
            set_depth(dc, dc, dc);
            for (int p = 0; p < 16; p++)
                for (int v = 0; v < 1024; v += 13)
                    px(v, (v * 3) % 1024, 1023 - v, 1'b1, p & 3, p >> 2, 1'b0, "R5 spatial");
        end

        // R2: output held while idle
        held = out_rgb;
        @(negedge clk);
        check(out_valid === 1'b0 && out_rgb === held, "R2 hold", {out_valid, out_rgb}, {1'b0, held});

        // R4: disabled pixels truncate
        for (int dc = 0; dc < 4; dc++) begin
            set_depth(dc, 3 - dc, (dc + 1) % 4);
            for (int v = 0; v < 1024; v += 17)
                px(v, 1023 - v, (v * 5) % 1024, 1'b0, v & 3, (v >> 2) & 3, 1'b0, "R4 truncate");
        end

        // R9: mixed depths per channel
        for (int m = 0; m < 64; m++) begin
            set_depth(m & 3, (m >> 2) & 3, (m >> 4) & 3);
            for (int p = 0; p < 16; p++)
                px((m * 37 + p * 11) % 1024, (m * 53 + 7) % 1024, (p * 61 + m) % 1024,
                   1'b1, p & 3, p >> 2, 1'b0, "R9 independent channels");
        end

        // R8: saturation near the top code
        for (int dc = 0; dc < 4; dc++) begin
            set_depth(dc, dc, dc);
            for (int p = 0; p < 16; p++) begin
                px(1023, 1022, 1020, 1'b1, p & 3, p >> 2, 1'b0, "R8 saturate");
                px(1008, 1015, 1019, 1'b1, p & 3, p >> 2, 1'b0, "R8 saturate");
            end
        end

        // R10: exact codes
        for (int dc = 0; dc < 4; dc++) begin
            set_depth(dc, dc, dc);
            for (int v = 0; v < 1024; v += 32)
                px(v, 992 - v, v, 1'b1, v & 3, (v >> 5) & 3, 1'b0, "R10 exact");
        end

        // R6 / R7: temporal sequence across a counter wrap
        cfg_temporal = 1'b1;
        set_depth(0, 1, 2);
        for (int f = 0; f < 18; f++) begin
            pulse();
            for (int p = 0; p < 16; p++) begin
                px(5 + p, 300 + 3 * p, 700 + f, 1'b1, p & 3, p >> 2, 1'b0, "R6 temporal");
                px(17 + f, 511, 1001 - p, 1'b1, p & 3, p >> 2, 1'b0, "R6 temporal");
            end
        end

        // R7: pulse together with a pixel uses the old count
        set_depth(0, 0, 0);
        for (int i = 0; i < 6; i++) begin
            px(9 + i, 21, 30, 1'b1, i & 3, 1, 1'b1, "R7 same-cycle pulse");
            px(9 + i, 21, 30, 1'b1, i & 3, 1, 1'b0, "R7 after pulse");
        end

        // R7 / R1: reset restarts the frame counter
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        fcnt = 0;
        @(negedge clk);
        for (int p = 0; p < 16; p++)
            px(3 + 2 * p, 13, 27, 1'b1, p & 3, p >> 2, 1'b0, "R7 count restart");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule